// File: doc/BRIEF.md
# Multi-Step Trigger Sequencer

This block is the trigger engine of an on-chip logic analyzer. It samples a 32-bit vector of sense signals every clock and walks through a programmed sequence of up to eight steps. Each step holds four match groups, a condition and an optional timer. A match group is a mask and value pair. The condition says how many matching events are needed and what to do once they have occurred: jump to a chosen step, or fire. Firing raises a one-cycle trigger pulse for a cross-trigger network and sets a level interrupt for a processor.

Software writes the configuration through a plain register write port while the block is off, then sets the enable bit. Progress through the sequence is kept from one cycle to the next, so a pattern can span many cycles. It is lost only when the sequence fires, when a step timer runs out, or when the block is disabled. The sense vector is sampled, not streamed, and the write port is always ready. Neither has back-pressure.

Register map (byte addresses on `cfg_addr`):
- 0x00 control: bit 0 enables the block. It is writable at any time.
- 0x01 status: writing 1 to bit 0 clears the interrupt.
- 0x80 | step<<4 | offset: step registers.
  - Offset 2g holds the mask of group g and offset 2g+1 its value.
  - Offset 8 is the condition word: bits [7:0] repeat count, bits [11:8] group enables (bit 8+g enables group g), bit 12 action (1 = fire, 0 = go to next step), bits [15:13] next step.
  - Offset 9 is the timer word: bits [15:0] limit, bit 16 timer on, bit 17 timer mode (1 = count events, 0 = count cycles).

Top module: `trig_seq`

## Requirements
- R1: After reset, `trig_o`, `irq_o`, `trig_grp_o` and `step_o` are all 0, and all step registers are zero.
- R2: Group g of the active step matches when it is enabled and `(sense_i & mask) == (value & mask)`. A cycle in which any enabled group matches is one event. Bits outside the mask have no effect.
- R3: When the sequence fires, `trig_grp_o` takes the lowest-numbered enabled group that matched in the firing cycle.
- R4: A step's condition is met on its Nth event, where N is the repeat count and a count of 0 acts as 1. The events need not be in consecutive cycles. The event count clears whenever a step is entered.
- R5: When a condition with action 0 is met, `step_o` becomes the programmed next step after that clock edge.
- R6: When a condition with action 1 is met, `trig_o` is high for the following cycle only, and the sequence returns to step 0.
- R7: `irq_o` is set in the same cycle `trig_o` rises. It stays high until a write of 1 to bit 0 at 0x01. A set in the same cycle as a clear wins.
- R8: With the timer on in cycle mode, if the timer count reaches a nonzero limit before the condition is met, the sequence returns to step 0 and the counters clear.
- R9: In event mode, the timer advances only on event cycles. If the condition is met in the cycle the limit is reached, the condition takes precedence.
- R10: While the enable bit is 0, `step_o` is held at 0, the counters are clear, `trig_o` stays low and sense activity is ignored.
- R11: Writes to step registers while the block is enabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| sense_i | input | 32 | Sense signals sampled each cycle |
| trig_o | output | 1 | One-cycle trigger pulse |
| irq_o | output | 1 | Level interrupt |
| trig_grp_o | output | 2 | Winning group of the last firing |
| step_o | output | 3 | Active step |

## Verification
The hardest case to reach from the ports is a step timer expiring in event mode on the very cycle the step's event count would otherwise advance. Reaching it requires climbing through step 0 with scattered events, then feeding the second step a measured number of events separated by idle cycles. The bench drives this twice. In the first run the limit is below the repeat count, so the step times out. In the second run the limit equals the repeat count, so the condition wins. A rejected write is shown through behaviour: the bench changes a match value while the block is enabled and then checks that the old pattern still advances the sequence while the new one does not.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int SENSE_W = 32;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NSTEP   = 8;
  localparam int NGRP    = 4;
  localparam int CNT_W   = 8;
  localparam int TMR_W   = 16;
  localparam int STEP_W  = $clog2(NSTEP);
  localparam int GRP_W   = $clog2(NGRP);
  localparam int OFF_W   = 4;

  localparam logic [ADDR_W-1:0] REG_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] REG_STAT = 8'h01;
  localparam logic [OFF_W-1:0]  OFF_COND = 4'd8;
  localparam logic [OFF_W-1:0]  OFF_TMR  = 4'd9;

  typedef struct packed {
    logic [STEP_W-1:0] nxt;
    logic              fire;
    logic [NGRP-1:0]   gen;
    logic [CNT_W-1:0]  rep;
  } cond_t;

  typedef struct packed {
    logic             by_evt;
    logic             on;
    logic [TMR_W-1:0] lim;
  } tmr_t;

  localparam int COND_BITS = $bits(cond_t);
  localparam int TMR_BITS  = $bits(tmr_t);
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [STEP_W-1:0]              sel_step,
  output logic                           en_o,
  output logic                           irq_clr_o,
  output logic [NGRP-1:0][SENSE_W-1:0]   mask_o,
  output logic [NGRP-1:0][SENSE_W-1:0]   val_o,
  output cond_t                          cond_o,
  output tmr_t                           tmr_o
);
  logic [NGRP-1:0][SENSE_W-1:0] mask_q [NSTEP];
  logic [NGRP-1:0][SENSE_W-1:0] val_q  [NSTEP];
  cond_t                        cond_q [NSTEP];
  tmr_t                         tmr_q  [NSTEP];
  logic                         en_q;
  logic                         step_wr;
  logic [STEP_W-1:0]            wr_step;
  logic [OFF_W-1:0]             wr_off;

  assign wr_step   = addr[OFF_W +: STEP_W];
  assign wr_off    = addr[OFF_W-1:0];
  assign step_wr   = we && addr[ADDR_W-1] && !en_q;
  assign irq_clr_o = we && (addr == REG_STAT) && wdata[0];
  assign en_o      = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         en_q <= 1'b0;
    else if (we && (addr == REG_CTRL))  en_q <= wdata[0];
  end

  for (genvar s = 0; s < NSTEP; s++) begin : g_step
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[s] <= '0;
        val_q[s]  <= '0;
        cond_q[s] <= '0;
        tmr_q[s]  <= '0;
      end else if (step_wr && (wr_step == STEP_W'(s))) begin
        if (!wr_off[OFF_W-1]) begin
          if (wr_off[0]) val_q[s][wr_off[GRP_W:1]]  <= wdata[SENSE_W-1:0];
          else           mask_q[s][wr_off[GRP_W:1]] <= wdata[SENSE_W-1:0];
        end else if (wr_off == OFF_COND) begin
          cond_q[s] <= cond_t'(wdata[COND_BITS-1:0]);
        end else if (wr_off == OFF_TMR) begin
          tmr_q[s] <= tmr_t'(wdata[TMR_BITS-1:0]);
        end
      end
    end
  end

  assign mask_o = mask_q[sel_step];
  assign val_o  = val_q[sel_step];
  assign cond_o = cond_q[sel_step];
  assign tmr_o  = tmr_q[sel_step];
endmodule

// File: rtl/trig_seq_match.sv
module trig_seq_match
  import trig_seq_pkg::*;
(
  input  logic [SENSE_W-1:0]            sense,
  input  logic [NGRP-1:0][SENSE_W-1:0]  mask,
  input  logic [NGRP-1:0][SENSE_W-1:0]  val,
  input  logic [NGRP-1:0]               gen,
  output logic                          hit,
  output logic [GRP_W-1:0]              win
);
  logic [NGRP-1:0] grp_m;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_m[g] = gen[g] && (((sense ^ val[g]) & mask[g]) == '0);
  end

  // lowest index has precedence
  always_comb begin
    win = '0;
    for (int g = NGRP-1; g >= 0; g--) begin
      if (grp_m[g]) win = GRP_W'(g);
    end
  end

  assign hit = |grp_m;
endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
  import trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hit,
  input  logic [GRP_W-1:0]  win,
  input  cond_t             cond,
  input  tmr_t              tcfg,
  input  logic              irq_clr,
  output logic [STEP_W-1:0] step_o,
  output logic              trig_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, rep_eff;
  logic [CNT_W:0]   cnt_inc;
  logic [TMR_W-1:0] tmr_q, tmr_inc;
  logic             met, tstep, tout, fire_now;

  always_comb begin
    rep_eff  = (cond.rep == '0) ? CNT_W'(1) : cond.rep;
    cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    met      = hit && (cnt_inc >= {1'b0, rep_eff});
    tstep    = tcfg.on && (tcfg.by_evt ? hit : 1'b1);
    tmr_inc  = tmr_q + TMR_W'(1);
    tout     = tstep && !met && (tcfg.lim != '0) && (tmr_inc == tcfg.lim);
    fire_now = en && met && cond.fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      step_o <= '0;
      cnt_q  <= '0;
      tmr_q  <= '0;
      trig_o <= 1'b0;
    end else begin
      trig_o <= fire_now;
      if (met) begin
        cnt_q  <= '0;
        tmr_q  <= '0;
        step_o <= cond.fire ? '0 : cond.nxt;
      end else if (tout) begin
        cnt_q  <= '0;
        tmr_q  <= '0;
        step_o <= '0;
      end else begin
        if (hit)   cnt_q <= cnt_inc[CNT_W-1:0];
        if (tstep) tmr_q <= tmr_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      grp_o <= '0;
    end else begin
      if (fire_now)     irq_o <= 1'b1;
      else if (irq_clr) irq_o <= 1'b0;
      if (fire_now)     grp_o <= win;
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       sense_i,
  output logic              trig_o,
  output logic              irq_o,
  output logic [1:0]        trig_grp_o,
  output logic [2:0]        step_o
);
  logic                         cfg_en, irq_clr, evt_hit;
  logic [GRP_W-1:0]             evt_win;
  logic [NGRP-1:0][SENSE_W-1:0] cur_mask, cur_val;
  cond_t                        cur_cond;
  tmr_t                         cur_tmr;

  trig_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_step(step_o), .en_o(cfg_en), .irq_clr_o(irq_clr),
    .mask_o(cur_mask), .val_o(cur_val), .cond_o(cur_cond), .tmr_o(cur_tmr)
  );

  trig_seq_match u_match (
    .sense(sense_i), .mask(cur_mask), .val(cur_val), .gen(cur_cond.gen),
    .hit(evt_hit), .win(evt_win)
  );

  trig_seq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .hit(evt_hit), .win(evt_win),
    .cond(cur_cond), .tcfg(cur_tmr), .irq_clr(irq_clr),
    .step_o(step_o), .trig_o(trig_o), .grp_o(trig_grp_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        hit,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        trig_o,
  input logic        irq_o,
  input logic [2:0]  step_o
);
  // R6
  trig_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (step_o == 3'd0));

  // R6
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(hit));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> irq_o);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h01 && cfg_wdata[0]) |=> (!irq_o || trig_o));

  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step_o == 3'd0 && !trig_o));

  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != $past(step_o) && step_o != 3'd0) |-> $past(hit));
endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg_en), .hit(evt_hit),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .trig_o(trig_o), .irq_o(irq_o), .step_o(step_o)
);

// File: tb/trig_seq_bench.sv
`timescale 1ns/1ps
module trig_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] sense_i = '0;
  logic        trig_o, irq_o;
  logic [1:0]  trig_grp_o;
  logic [2:0]  step_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       tr;
    logic [2:0] st;
    logic       irq;
    logic       cg;
    logic [1:0] g;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  trig_seq u_trig_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sense_i(sense_i), .trig_o(trig_o), .irq_o(irq_o),
    .trig_grp_o(trig_grp_o), .step_o(step_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one sense cycle and queue the outputs expected after the next edge
  task automatic cyc(input logic [31:0] s, input logic tr, input logic [2:0] st,
                     input logic irq, input string tag,
                     input logic cg = 1'b0, input logic [1:0] g = 2'd0);
    exp_t e;
    @(negedge clk);
    sense_i = s;
    e.tr = tr; e.st = st; e.irq = irq; e.cg = cg; e.g = g; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(trig_o == e.tr, e.tag, "trig_o", int'(trig_o), int'(e.tr));
        chk(step_o == e.st, e.tag, "step_o", int'(step_o), int'(e.st));
        chk(irq_o == e.irq, e.tag, "irq_o", int'(irq_o), int'(e.irq));
        if (e.cg) chk(trig_grp_o == e.g, e.tag, "trig_grp_o", int'(trig_grp_o), int'(e.g));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic climb();  // three step-0 events reach step 5
    cyc(32'h12, 0, 0, 0, "R4 first");
    cyc(32'h12, 0, 0, 0, "R4 second");
    cyc(32'h12, 0, 5, 0, "R5 third");
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_o == 0, "R1", "trig_o", int'(trig_o), 0);
    chk(irq_o == 0, "R1", "irq_o", int'(irq_o), 0);
    chk(step_o == 0, "R1", "step_o", int'(step_o), 0);
    chk(trig_grp_o == 0, "R1", "trig_grp_o", int'(trig_grp_o), 0);

    // step 0: group 0 low byte 0x12, three events, go to step 5
    wr(8'h80, 32'hFF); wr(8'h81, 32'h12); wr(8'h88, 32'hA103);
    // step 5: groups 1 and 2, count 0, fire
    wr(8'hD2, 32'hF00);  wr(8'hD3, 32'h300);
    wr(8'hD4, 32'hF000); wr(8'hD5, 32'h5000);
    wr(8'hD8, 32'h1600);
    wr(8'h00, 32'h1);

    cyc(32'h12, 0, 0, 0, "R4 one event");
    cyc(32'h34, 0, 0, 0, "R2 mismatch");
    cyc(32'hABCD0012, 0, 0, 0, "R2 unmasked bits ignored");
    cyc(32'h12, 0, 5, 0, "R5 goto step 5");
    cyc(32'h5300, 1, 0, 1, "R3 R6 fire group1 wins", 1'b1, 2'd1);
    cyc(32'h0, 0, 0, 1, "R6 pulse R7 level");
    wr(8'h01, 32'h1);
    chk(irq_o == 0, "R7 clear", "irq_o", int'(irq_o), 0);

    climb();
    cyc(32'h5000, 1, 0, 1, "R3 R4 group2 count zero", 1'b1, 2'd2);
    cyc(32'h0, 0, 0, 1, "R7 held");
    wr(8'h01, 32'h1);

    // R11: write while enabled must not change step 0 value
    wr(8'h81, 32'h34);
    cyc(32'h34, 0, 0, 0, "R11 ignored write");
    cyc(32'h34, 0, 0, 0, "R11 ignored write");
    cyc(32'h34, 0, 0, 0, "R11 ignored write");
    climb();
    cyc(32'h0, 0, 5, 0, "R4 idle hold");

    // R10: disable clears progress, sense ignored
    wr(8'h00, 32'h0);
    cyc(32'h12, 0, 0, 0, "R10 cleared");
    cyc(32'h12, 0, 0, 0, "R10 ignored");
    cyc(32'h12, 0, 0, 0, "R10 ignored");
    cyc(32'h0, 0, 0, 0, "R10 idle");
    wr(8'h00, 32'h1);
    climb();
    cyc(32'h5000, 1, 0, 1, "R6 fire again", 1'b1, 2'd2);
    cyc(32'h0, 0, 0, 1, "R7 held");
    wr(8'h01, 32'h1);

    // R8: cycle timer limit 4 on step 5
    wr(8'h00, 32'h0);
    wr(8'hD9, 32'h10004);
    wr(8'h00, 32'h1);
    climb();
    cyc(32'h0, 0, 5, 0, "R8 tmr1");
    cyc(32'h0, 0, 5, 0, "R8 tmr2");
    cyc(32'h0, 0, 5, 0, "R8 tmr3");
    cyc(32'h0, 0, 0, 0, "R8 timeout");
    cyc(32'h5000, 0, 0, 0, "R8 back at step 0");
    cyc(32'h0, 0, 0, 0, "R8 idle");

    // R9: event timer limit 2, repeat 3
    wr(8'h00, 32'h0);
    wr(8'hD8, 32'h1603);
    wr(8'hD9, 32'h30002);
    wr(8'h00, 32'h1);
    climb();
    cyc(32'h5000, 0, 5, 0, "R9 event one");
    cyc(32'h0, 0, 5, 0, "R9 idle not counted");
    cyc(32'h0, 0, 5, 0, "R9 idle not counted");
    cyc(32'h0, 0, 5, 0, "R9 idle not counted");
    cyc(32'h5000, 0, 0, 0, "R9 timeout on event");
    cyc(32'h0, 0, 0, 0, "R9 idle");

    // R9: limit equals repeat count, condition wins
    wr(8'h00, 32'h0);
    wr(8'hD9, 32'h30003);
    wr(8'h00, 32'h1);
    climb();
    cyc(32'h5000, 0, 5, 0, "R9 event one");
    cyc(32'h5000, 0, 5, 0, "R9 event two");
    cyc(32'h5000, 1, 0, 1, "R9 condition wins", 1'b1, 2'd2);
    cyc(32'h0, 0, 0, 1, "R7 held");
    wr(8'h01, 32'h1);
    chk(irq_o == 0, "R7 clear", "irq_o", int'(irq_o), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule